// File: doc/BRIEF.md
# Checked Management Register Access Sequencer

This block sits on the host side of a management bus. It turns one register read or write into a short series of primitive bus transactions, and it verifies each series with an 8-bit checksum. A request carries a direction flag, a 5-bit PHY address, a 5-bit register address and 16 bits of write data. The block then drives a simple command port: a start pulse with direction, address and data, answered later by a done pulse with a bus-error flag and read data. The serial bit-level master behind that port is a separate block.

Each attempt arms the target's error check, performs the access, and then exchanges the checksum through the target's check register. A failed check repeats the whole attempt until the retry limit is spent. A retry limit of zero means the block checks once and does not repeat. A bus error on any transaction ends the request at once. When the request finishes, the block gives a one-cycle done pulse with an error flag and, for reads, the data returned.

Top module: `mgmt_checked_access`

## Requirements
- R1: Every attempt starts with a write of 16'h0001 to absolute address 10'h33A. The absolute address is {PHY address, register address}, so this is PHY 5'h19, register 5'h1A. This command is issued in the cycle after a request is accepted.
- R2: A write attempt issues four commands in this order: the enable write, the data write to the requested address, a write of the zero-extended checksum to absolute address 10'h339, and a read of 10'h339. A set bit 8 in the value read back marks a mismatch.
- R3: A read attempt issues three commands in this order: the enable write, the data read, and a read of 10'h339. The attempt passes only if all 16 bits returned equal the zero-extended checksum of the data read. The data read appears on rdata when the request finishes.
- R4: Checksum bit i (i from 0 to 7) is data[i] ^ data[i+8] ^ addr[i]. Bits 0 and 1 also fold in addr[8] and addr[9]. Bits 2 and 3 also fold in opcode bits 0 and 1. The opcode is 2'b01 for a write and 2'b10 for a read.
- R5: With cfg_retries = N > 0, a failed check repeats the whole attempt. If all N attempts fail, the request ends with err set.
- R6: With cfg_retries = 0, exactly one attempt is made, and a mismatch ends the request with err set.
- R7: A bus error reported with any command done ends the request in the next cycle with err set. No further command is issued.
- R8: A passing check ends the request with done pulsed and err clear.
- R9: A request that arrives while busy is ignored. The command sequence and the result of the request in progress are unchanged.
- R10: done is high for exactly one cycle, and busy is low while done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, accepted when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | PHY address of the access |
| req_reg | input | 5 | Register address of the access |
| req_wdata | input | 16 | Write data |
| cfg_retries | input | CNT_W | Attempt limit, latched with the request |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Result of the last request failed |
| rdata | output | 16 | Data from the last data read |
| cmd_start | output | 1 | One-cycle command launch |
| cmd_write | output | 1 | Command direction, held until cmd_done |
| cmd_phy | output | 5 | Command PHY address |
| cmd_reg | output | 5 | Command register address |
| cmd_wdata | output | 16 | Command write data (zero for reads) |
| cmd_done | input | 1 | Command completion pulse |
| cmd_buserr | input | 1 | Bus error, valid with cmd_done |
| cmd_rdata | input | 16 | Read data, valid with cmd_done |

## Verification
The assertions assume that the command port returns a done pulse only for a command still outstanding, and never in the cycle that command starts. The bench's bus-target model keeps to this: it waits one to three cycles after each start before it answers. That model records every command and corrupts checksum replies for a chosen number of attempts. It can also raise a bus error on a chosen command index. Random cases pick the limit, the failure count, the error position and a stray request issued while busy.

// File: rtl/mgmt_checked_access.sv
module mgmt_checked_access #(
  parameter int CNT_W = 4,
  parameter logic [9:0] CTRL_ADDR = 10'h33A,
  parameter logic [9:0] CHK_ADDR  = 10'h339
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [4:0]       req_phy,
  input  logic [4:0]       req_reg,
  input  logic [15:0]      req_wdata,
  input  logic [CNT_W-1:0] cfg_retries,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [15:0]      rdata,
  output logic             cmd_start,
  output logic             cmd_write,
  output logic [4:0]       cmd_phy,
  output logic [4:0]       cmd_reg,
  output logic [15:0]      cmd_wdata,
  input  logic             cmd_done,
  input  logic             cmd_buserr,
  input  logic [15:0]      cmd_rdata
);

  typedef enum logic [2:0] {S_IDLE, S_EN, S_XFER, S_SUMW, S_SUMR} st_t;

  st_t              st;
  logic             wr_q;
  logic [9:0]       addr_q;
  logic [15:0]      wdata_q;
  logic [CNT_W-1:0] lim_q, tries_q;

  function automatic logic [7:0] csum(input logic [15:0] d, input logic [9:0] a, input logic [1:0] op);
    logic [7:0] s;
    for (int i = 0; i < 8; i++) begin
      s[i] = d[i] ^ d[i+8] ^ a[i];
      if (i < 2)      s[i] = s[i] ^ a[i+8];
      else if (i < 4) s[i] = s[i] ^ op[i-2];
    end
    return s;
  endfunction

  logic [7:0]       sum_q;
  logic [CNT_W-1:0] eff_lim;
  logic             mism, last;
  logic [9:0]       cmd_addr;

  assign sum_q   = wr_q ? csum(wdata_q, addr_q, 2'b01) : csum(rdata, addr_q, 2'b10);
  assign mism    = wr_q ? cmd_rdata[8] : (cmd_rdata != {8'h00, sum_q});
  assign eff_lim = (lim_q == '0) ? CNT_W'(1) : lim_q;
  assign last    = ({1'b0, tries_q} + 1'b1) >= {1'b0, eff_lim};
  assign busy    = (st != S_IDLE);

  always_comb begin
    cmd_write = 1'b0;
    cmd_addr  = CHK_ADDR;
    cmd_wdata = '0;
    case (st)
      S_EN:   begin cmd_write = 1'b1; cmd_addr = CTRL_ADDR; cmd_wdata = 16'h0001; end
      S_XFER: begin cmd_write = wr_q; cmd_addr = addr_q; cmd_wdata = wr_q ? wdata_q : '0; end
      S_SUMW: begin cmd_write = 1'b1; cmd_wdata = {8'h00, sum_q}; end
      default: ;
    endcase
  end
  assign {cmd_phy, cmd_reg} = cmd_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; wr_q <= 1'b0; addr_q <= '0; wdata_q <= '0;
      lim_q <= '0; tries_q <= '0; rdata <= '0;
      done <= 1'b0; err <= 1'b0; cmd_start <= 1'b0;
    end else begin
      done      <= 1'b0;
      cmd_start <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          wr_q <= req_write; addr_q <= {req_phy, req_reg}; wdata_q <= req_wdata;
          lim_q <= cfg_retries; tries_q <= '0; err <= 1'b0;
          st <= S_EN; cmd_start <= 1'b1;
        end
        default: if (cmd_done) begin
          if (cmd_buserr) begin
            st <= S_IDLE; done <= 1'b1; err <= 1'b1;
          end else begin
            case (st)
              S_EN:   begin st <= S_XFER; cmd_start <= 1'b1; end
              S_XFER: begin
                if (!wr_q) rdata <= cmd_rdata;
                st <= wr_q ? S_SUMW : S_SUMR; cmd_start <= 1'b1;
              end
              S_SUMW: begin st <= S_SUMR; cmd_start <= 1'b1; end
              default: begin
                if (!mism) begin
                  st <= S_IDLE; done <= 1'b1; err <= 1'b0;
                end else if (last) begin
                  st <= S_IDLE; done <= 1'b1; err <= 1'b1;
                end else begin
                  tries_q <= tries_q + 1'b1; st <= S_EN; cmd_start <= 1'b1;
                end
              end
            endcase
          end
        end
      endcase
    end
  end

  AST_ENABLE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> (cmd_start && cmd_write && {cmd_phy, cmd_reg} == CTRL_ADDR && cmd_wdata == 16'h0001)); // R1
  AST_BUSERR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_done && cmd_buserr) |=> (done && err && !busy && !cmd_start)); // R7
  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cmd_done) |=> $stable({cmd_write, cmd_phy, cmd_reg, cmd_wdata})); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10
  AST_SINGLE_START: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> !cmd_start); // R2
endmodule

// File: tb/test_mgmt_checked_access.sv
module test_mgmt_checked_access;
  localparam int CNT_W = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [4:0] req_phy = '0, req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic [CNT_W-1:0] cfg_retries = '0;
  logic busy, done, err, cmd_start, cmd_write;
  logic [15:0] rdata, cmd_wdata;
  logic [4:0] cmd_phy, cmd_reg;
  logic cmd_done = 1'b0, cmd_buserr = 1'b0;
  logic [15:0] cmd_rdata = '0;

  always #2.5 clk = ~clk;

  mgmt_checked_access #(.CNT_W(CNT_W)) i_mgmt_checked_access (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata), .cfg_retries(cfg_retries),
    .busy(busy), .done(done), .err(err), .rdata(rdata),
    .cmd_start(cmd_start), .cmd_write(cmd_write), .cmd_phy(cmd_phy), .cmd_reg(cmd_reg),
    .cmd_wdata(cmd_wdata), .cmd_done(cmd_done), .cmd_buserr(cmd_buserr), .cmd_rdata(cmd_rdata));

  int checks = 0, fails = 0, cycles = 0;
  bit finished = 0;

  bit m_wr; logic [9:0] m_addr; logic [15:0] m_rv; int m_k, m_be, m_att, n_log;
  logic l_w [64]; logic [9:0] l_a [64]; logic [15:0] l_d [64];

  function automatic logic [7:0] ref_sum(input logic [15:0] d, input logic [9:0] a, input logic [1:0] op);
    return d[7:0] ^ d[15:8] ^ a[7:0] ^ {4'b0000, op, a[9:8]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin : responder
    int lat; bit pend, be; logic [15:0] resp;
    pend = 0; lat = 0; be = 0; resp = '0;
    forever begin
      @(negedge clk);
      cmd_done = 1'b0; cmd_buserr = 1'b0;
      if (cmd_start) begin
        if (n_log < 64) begin
          l_w[n_log] = cmd_write; l_a[n_log] = {cmd_phy, cmd_reg}; l_d[n_log] = cmd_wdata;
        end
        be = (n_log == m_be);
        n_log++;
        if (cmd_write && {cmd_phy, cmd_reg} == 10'h33A) m_att++;
        resp = '0;
        if (!cmd_write && {cmd_phy, cmd_reg} == 10'h339) begin
          if (m_wr) resp = (m_att <= m_k) ? 16'h0100 : 16'h0000;
          else resp = {8'h00, ref_sum(m_rv, m_addr, 2'b10)} ^ ((m_att <= m_k) ? 16'h0001 : 16'h0000);
        end else if (!cmd_write) resp = m_rv;
        lat = 1 + int'($urandom % 3); pend = 1;
      end else if (pend) begin
        lat--;
        if (lat == 0) begin
          cmd_done = 1'b1; cmd_buserr = be; cmd_rdata = resp; pend = 0;
        end
      end
    end
  end

  task automatic access(input bit w, input logic [9:0] a, input logic [15:0] wd, input logic [15:0] rv,
                        input int n, input int k, input int be_idx, input bit poke);
    logic ew [64]; logic [9:0] ea [64]; logic [15:0] ed [64];
    int ec = 0, lim; bit fin = 0, exp_err = 0, seq_ok, got_err;
    string tseq;
    @(negedge clk);
    m_wr = w; m_addr = a; m_rv = rv; m_k = k; m_be = be_idx; m_att = 0; n_log = 0;
    req_valid = 1'b1; req_write = w; {req_phy, req_reg} = a; req_wdata = wd; cfg_retries = CNT_W'(n);
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      @(negedge clk);
      req_valid = 1'b1; req_write = ~w; {req_phy, req_reg} = ~a; req_wdata = ~wd;
      cfg_retries = CNT_W'($urandom % 6);
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (!done && !finished) @(negedge clk);
    got_err = err;
    chk(!busy, "R10 busy low with done", 32'(busy), 0);
    lim = (n == 0) ? 1 : n;
    for (int t = 0; t < 16 && !fin; t++) begin
      for (int j = 0; j < (w ? 4 : 3) && !fin; j++) begin
        if (j == 0) begin ew[ec] = 1; ea[ec] = 10'h33A; ed[ec] = 16'h0001; end
        else if (j == 1) begin ew[ec] = w; ea[ec] = a; ed[ec] = wd; end
        else if (j == 2 && w) begin ew[ec] = 1; ea[ec] = 10'h339; ed[ec] = {8'h00, ref_sum(wd, a, 2'b01)}; end
        else begin ew[ec] = 0; ea[ec] = 10'h339; ed[ec] = '0; end
        if (ec == be_idx) begin fin = 1; exp_err = 1; end
        ec++;
      end
      if (!fin) begin
        if (t >= k) begin fin = 1; exp_err = 0; end
        else if (t + 1 >= lim) begin fin = 1; exp_err = 1; end
      end
    end
    seq_ok = (n_log == ec);
    for (int i = 0; i < ec && i < n_log; i++)
      if (l_w[i] != ew[i] || l_a[i] != ea[i] || (ew[i] && l_d[i] != ed[i])) seq_ok = 0;
    tseq = w ? "R1 R2 R4 sequence" : "R1 R3 sequence";
    if (be_idx >= 0 && be_idx < ec) tseq = {tseq, " R7"};
    if (n == 0) tseq = {tseq, " R6"}; else tseq = {tseq, " R5"};
    if (poke) tseq = {tseq, " R9"};
    chk(seq_ok, tseq, 32'(n_log), 32'(ec));
    chk(got_err == exp_err, exp_err ? "R5 R6 R7 err set" : "R8 err clear", 32'(got_err), 32'(exp_err));
    if (!w && (be_idx < 0 || be_idx > 1))
      chk(rdata == rv, "R3 rdata", 32'(rdata), 32'(rv));
    @(negedge clk);
    chk(!done, "R10 done one cycle", 32'(done), 0);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 150000 && !finished) begin
        finished = 1; fails++;
        $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
      end
    end
  end

  initial begin : main
    void'($urandom(32'd1234));
    m_be = -1; m_att = 0; n_log = 0; m_k = 0; m_wr = 0; m_addr = '0; m_rv = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !err && !cmd_start, "R10 reset state", {busy, done, err, cmd_start}, 0);
    access(1, 10'h0A3, 16'hBEEF, 16'h0, 3, 0, -1, 0);
    access(0, 10'h2C5, 16'h0, 16'h1234, 3, 0, -1, 0);
    access(1, 10'h3FF, 16'hFFFF, 16'h0, 3, 2, -1, 0);
    access(1, 10'h001, 16'h8001, 16'h0, 3, 3, -1, 0);
    access(0, 10'h155, 16'h0, 16'hA5A5, 0, 5, -1, 0);
    access(0, 10'h2AA, 16'h0, 16'h5A5A, 0, 0, -1, 0);
    access(0, 10'h0F0, 16'h0, 16'hFF00, 2, 1, -1, 0);
    for (int b = 0; b < 4; b++) access(1, 10'h123, 16'h0F0F, 16'h0, 3, 1, b, 0);
    access(0, 10'h321, 16'h0, 16'h00FF, 3, 0, 2, 0);
    access(1, 10'h0C3, 16'h7777, 16'h0, 2, 1, -1, 1);
    access(0, 10'h3C0, 16'h0, 16'hC0DE, 1, 0, -1, 1);
    for (int r = 0; r < 60; r++)
      access(bit'($urandom % 2), 10'($urandom), 16'($urandom), 16'($urandom),
             int'($urandom % 6), int'($urandom % 7),
             ($urandom % 4 == 0) ? int'($urandom % 10) : -1, bit'($urandom % 3 == 0));
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule